// File: doc/BRIEF.md
# Multi-channel output-compare periodic timer

This block is a timer peripheral built around one shared up-counter that advances on prescaled ticks. Several independent compare channels observe the counter. Each channel holds a compare value, a step, a sticky match flag, an interrupt enable and a two-bit pin mode. When a tick brings the counter onto a channel's compare value, the channel sets its flag, updates its output pin, and in the same clock edge reloads its compare value with the old value plus its step, reduced modulo the counter period. Every channel therefore repeats at its own interval, and no channel needs the shared counter limit to be changed.

Software configures the block through a plain write strobe and reads it back through a combinational read port. The address map is as follows. Address 0 holds the prescaler select, address 1 the counter limit, and address 2 returns the live counter. Channel i has its registers at base 4*(i+1): +0 configuration (bit 0 interrupt enable, bits 2:1 pin mode, bit 3 flag), +1 compare value, +2 step, and +3 a write-only arm register. A write to the arm register loads the compare value relative to the current count, so that channels can be spread apart.

Top module: `oc_multi_timer`

## Requirements
- R1: After reset the prescaler select reads 0 (stopped), the counter limit reads 0xFFFF, the counter reads 0, and every channel's configuration, compare value, step, flag, pin and interrupt reads 0.
- R2: A prescaler select p from 1 to 7 (address 0, bits 2:0) produces one counter tick every 2^(p-1) clocks, counted from the write. With p=4 the counter advances once every 8 clocks. Writing any value to address 0 restarts the divider.
- R3: Writing 0 to the prescaler select stops the counter and forces it to 0. It then holds 0 until a nonzero select is written.
- R4: On each tick the counter increments, and it returns to 0 on the tick after it equals the counter limit. With the default limit 0xFFFF it runs freely through the full 16-bit range.
- R5: When a tick moves the counter onto a channel's compare value, that channel's flag (configuration bit 3) becomes 1 on the same edge. irq[i] is flag AND enable, and irq_any is the OR of all irq lines.
- R6: A flag clears only when the channel's configuration is written with bit 3 equal to 0. Writing bit 3 as 1 leaves the flag unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: On a match the compare value becomes (compare + step) modulo (limit + 1) on that same edge, with no software write. Channels with different steps therefore repeat at different intervals under one shared limit. A direct write to the compare value takes priority over the reload.
- R8: The pin mode decides the pin action on a match: 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R9: A write of offset d to a channel's arm register sets its compare value to (counter + d) modulo (limit + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CW | Read data, combinational |
| oc_pin | output | NCH | Per-channel compare output pins |
| irq | output | NCH | Per-channel interrupt requests |
| irq_any | output | 1 | OR of all channel interrupt requests |

## Verification
The bound assertions check four things on every cycle. The counter only steps by one or returns to zero. A stop write clears it. A flag rises, a pin changes, or a compare value moves without a write only on the edge where a tick lands the counter on that compare value. A flag never falls without a write. The exact modular reload amount, the prescaler rate, the pin mode semantics and the independence of channel periods under a shared limit can only be shown by the bench. It sweeps every step against a small limit and counts pin transitions over whole counter periods, comparing the results with values it computes arithmetically.

// File: rtl/oc_multi_timer.sv
module oc_multi_timer #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] oc_pin,
  output logic [NCH-1:0] irq,
  output logic           irq_any
);
  localparam int PRW = (1 << PSW) - 2;
  localparam int CHB = 4;

  logic [PSW-1:0] ps;
  logic [PRW-1:0] pre, pmask;
  logic [CW-1:0]  modv, cnt, cnt_nxt;
  logic           tick, ctl_wr, stop_wr;

  logic [NCH-1:0][CW-1:0] cmp, step;
  logic [NCH-1:0][1:0]    mode;
  logic [NCH-1:0]         ie, flag, pin, match;

  function automatic logic [CW-1:0] addmod(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                           input logic [CW-1:0] m);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s > {1'b0, m}) s = s - ({1'b0, m} + 1'b1);
    return s[CW-1:0];
  endfunction

  assign pmask   = PRW'((32'd1 << (ps - 1'b1)) - 32'd1);
  assign tick    = (ps != '0) && ((pre & pmask) == pmask);
  assign ctl_wr  = wr_en && (wr_addr == AW'(0));
  assign stop_wr = ctl_wr && (wr_data[PSW-1:0] == '0);
  assign cnt_nxt = (cnt == modv) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps   <= '0;
      pre  <= '0;
      modv <= '1;
      cnt  <= '0;
    end else begin
      pre <= ctl_wr ? '0 : pre + 1'b1;
      if (ctl_wr) ps <= wr_data[PSW-1:0];
      if (wr_en && wr_addr == AW'(1)) modv <= wr_data;
      if (stop_wr) cnt <= '0;
      else if (tick) cnt <= cnt_nxt;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int BASE = CHB * (i + 1);
    logic          wr_cfg, wr_cmp, wr_stp, wr_arm;
    logic          f_q, p_q, ie_q;
    logic [1:0]    md_q;
    logic [CW-1:0] cmp_q, stp_q;

    assign wr_cfg   = wr_en && (wr_addr == AW'(BASE));
    assign wr_cmp   = wr_en && (wr_addr == AW'(BASE + 1));
    assign wr_stp   = wr_en && (wr_addr == AW'(BASE + 2));
    assign wr_arm   = wr_en && (wr_addr == AW'(BASE + 3));
    assign match[i] = tick && !stop_wr && (cnt_nxt == cmp_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_q   <= 1'b0;
        p_q   <= 1'b0;
        ie_q  <= 1'b0;
        md_q  <= 2'b00;
        cmp_q <= '0;
        stp_q <= '0;
      end else begin
        if (wr_cfg) begin
          ie_q <= wr_data[0];
          md_q <= wr_data[2:1];
        end
        if (match[i]) f_q <= 1'b1;
        else if (wr_cfg && !wr_data[3]) f_q <= 1'b0;
        if (wr_cmp) cmp_q <= wr_data;
        else if (wr_arm) cmp_q <= addmod(cnt, wr_data, modv);
        else if (match[i]) cmp_q <= addmod(cmp_q, stp_q, modv);
        if (wr_stp) stp_q <= wr_data;
        if (match[i]) begin
          case (md_q)
            2'b01:   p_q <= ~p_q;
            2'b10:   p_q <= 1'b0;
            2'b11:   p_q <= 1'b1;
            default: p_q <= p_q;
          endcase
        end
      end
    end

    assign flag[i] = f_q;
    assign pin[i]  = p_q;
    assign ie[i]   = ie_q;
    assign mode[i] = md_q;
    assign cmp[i]  = cmp_q;
    assign step[i] = stp_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(0)) rd_data = CW'(ps);
    if (rd_addr == AW'(1)) rd_data = modv;
    if (rd_addr == AW'(2)) rd_data = cnt;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(CHB * (i + 1)))     rd_data = CW'({flag[i], mode[i], ie[i]});
      if (rd_addr == AW'(CHB * (i + 1) + 1)) rd_data = cmp[i];
      if (rd_addr == AW'(CHB * (i + 1) + 2)) rd_data = step[i];
    end
  end

  assign oc_pin  = pin;
  assign irq     = flag & ie;
  assign irq_any = |irq;
endmodule

module oc_multi_timer_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   tick,
  input logic                   stop_wr,
  input logic [CW-1:0]          cnt,
  input logic [NCH-1:0][CW-1:0] cmp,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         pin
);
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0)); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (cnt == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop_wr) |=> $stable(cnt)); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(tick) && (cnt == $past(cmp[i]))); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(wr_en)); // R6
    AST_REARM_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && (cmp[i] != $past(cmp[i]))) |-> flag[i] && (cnt == $past(cmp[i]))); // R7
    AST_PIN_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin[i]) |-> $past(tick) && (cnt == $past(cmp[i]))); // R8
  end
endmodule

bind oc_multi_timer oc_multi_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .stop_wr(stop_wr),
  .cnt(cnt), .cmp(cmp), .flag(flag), .pin(pin)
);

// File: tb/oc_multi_timer_tb.sv
`timescale 1ns/1ps
module oc_multi_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = 5'd2;
  logic [15:0] rd_data;
  logic [3:0]  oc_pin, irq;
  logic        irq_any;

  int nvec = 0, nfail = 0;
  bit live = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  oc_multi_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .oc_pin(oc_pin), .irq(irq), .irq_any(irq_any)
  );

  logic [2:0]  m_ps;
  logic [5:0]  m_pre;
  logic [15:0] m_mod, m_cnt;
  logic [15:0] m_cmp [4];
  logic [15:0] m_step [4];
  logic [1:0]  m_mode [4];
  logic [3:0]  m_ie, m_flag, m_pin;

  function automatic logic [15:0] addm(input int a, input int b, input int m);
    int s;
    s = a + b;
    if (s > m) s = s - (m + 1);
    return 16'(s);
  endfunction

  always @(posedge clk) begin : model
    logic tk, sw;
    logic [5:0] mk;
    logic [15:0] nx;
    logic [3:0] mt;
    if (!rst_n) begin
      m_ps = '0; m_pre = '0; m_mod = 16'hFFFF; m_cnt = '0;
      m_ie = '0; m_flag = '0; m_pin = '0;
      for (int i = 0; i < 4; i++) begin
        m_cmp[i] = '0; m_step[i] = '0; m_mode[i] = '0;
      end
    end else begin
      mk = (m_ps == 0) ? 6'd0 : 6'((7'd1 << (m_ps - 1)) - 7'd1);
      tk = (m_ps != 0) && ((m_pre & mk) == mk);
      sw = wr_en && wr_addr == 5'd0 && wr_data[2:0] == 3'd0;
      nx = (m_cnt == m_mod) ? 16'd0 : m_cnt + 16'd1;
      for (int i = 0; i < 4; i++) mt[i] = tk && !sw && (nx == m_cmp[i]);
      for (int i = 0; i < 4; i++) begin
        if (mt[i]) begin
          if (m_mode[i] == 2'b01) m_pin[i] = ~m_pin[i];
          else if (m_mode[i] == 2'b10) m_pin[i] = 1'b0;
          else if (m_mode[i] == 2'b11) m_pin[i] = 1'b1;
        end
        if (mt[i]) m_flag[i] = 1'b1;
        else if (wr_en && wr_addr == 5'(4*(i+1)) && !wr_data[3]) m_flag[i] = 1'b0;
        if (wr_en && wr_addr == 5'(4*(i+1))) begin
          m_ie[i] = wr_data[0]; m_mode[i] = wr_data[2:1];
        end
        if (wr_en && wr_addr == 5'(4*(i+1)+1)) m_cmp[i] = wr_data;
        else if (wr_en && wr_addr == 5'(4*(i+1)+3)) m_cmp[i] = addm(m_cnt, wr_data, m_mod);
        else if (mt[i]) m_cmp[i] = addm(m_cmp[i], m_step[i], m_mod);
        if (wr_en && wr_addr == 5'(4*(i+1)+2)) m_step[i] = wr_data;
      end
      m_pre = (wr_en && wr_addr == 5'd0) ? 6'd0 : m_pre + 6'd1;
      if (wr_en && wr_addr == 5'd0) m_ps = wr_data[2:0];
      if (wr_en && wr_addr == 5'd1) m_mod = wr_data;
      if (sw) m_cnt = '0;
      else if (tk) m_cnt = nx;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      if (nfail < 30) $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live) begin
      check("R8 pins", 16'(oc_pin), 16'(m_pin));
      check("R5 irq", 16'(irq), 16'(m_flag & m_ie));
      check("R5 irq_any", 16'(irq_any), 16'(|(m_flag & m_ie)));
      if (rd_addr == 5'd2) check("R4 counter", rd_data, m_cnt);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    #2 rd_addr = a;
    #1 check(tag, rd_data, exp);
    rd_addr = 5'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic p0, p1;
    int  c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    // R1 reset state
    rd(5'd0, 16'd0, "R1 prescaler");
    rd(5'd1, 16'hFFFF, "R1 limit");
    rd(5'd2, 16'd0, "R1 counter");
    for (int i = 0; i < 4; i++) begin
      rd(5'(4*(i+1)), 16'd0, "R1 cfg");
      rd(5'(4*(i+1)+1), 16'd0, "R1 compare");
      rd(5'(4*(i+1)+2), 16'd0, "R1 step");
    end
    check("R1 pins", 16'(oc_pin), 16'd0);
    idle(10);
    rd(5'd2, 16'd0, "R3 stays stopped");

    // R2 divide by 8 then by 2
    wr(5'd0, 16'd4);
    repeat (800) @(posedge clk);
    rd(5'd2, 16'd100, "R2 div8 count");
    wr(5'd0, 16'd0);
    wr(5'd0, 16'd2);
    repeat (100) @(posedge clk);
    rd(5'd2, 16'd50, "R2 div2 count");

    // R3 stop clears counter
    wr(5'd0, 16'd0);
    rd(5'd2, 16'd0, "R3 cleared");
    idle(20);
    rd(5'd2, 16'd0, "R3 held");

    // R7 wrap at default 16-bit limit, R5/R6 flag behaviour
    wr(5'd13, 16'h0030);
    wr(5'd14, 16'hFFF0);
    wr(5'd12, 16'd1);
    wr(5'd0, 16'd1);
    idle(60);
    rd(5'd13, 16'h0020, "R7 wrap full range");
    rd(5'd12, 16'h0009, "R5 flag set");
    check("R5 irq2", 16'(irq[2]), 16'd1);
    wr(5'd12, 16'h0009);
    rd(5'd12, 16'h0009, "R6 write one keeps flag");
    wr(5'd12, 16'h0001);
    rd(5'd12, 16'h0001, "R6 write zero clears");
    check("R6 irq2 low", 16'(irq[2]), 16'd0);
    wr(5'd12, 16'h0008);
    rd(5'd12, 16'h0000, "R6 write one does not set");

    // R7 reload modulo small limit
    wr(5'd0, 16'd0);
    wr(5'd1, 16'd63);
    wr(5'd5, 16'd60);
    wr(5'd6, 16'd10);
    wr(5'd0, 16'd1);
    idle(62);
    rd(5'd5, 16'd6, "R7 reload mod 64");

    // R8 sweep of every step with all pin modes
    wr(5'd4, 16'd3);
    wr(5'd8, 16'd7);  wr(5'd10, 16'd16); wr(5'd11, 16'd3);
    wr(5'd12, 16'd5); wr(5'd14, 16'd24); wr(5'd15, 16'd9);
    wr(5'd16, 16'd1); wr(5'd18, 16'd5);  wr(5'd19, 16'd1);
    for (int s = 1; s < 64; s++) begin
      wr(5'd6, 16'(s));
      wr(5'd7, 16'(s));
      for (int k = 0; k < 3; k++) begin
        idle(40);
        wr(5'd4, 16'd3);
        wr(5'd8, 16'd7);
        wr(5'd12, 16'd5);
        wr(5'd16, 16'd1);
      end
      if (s == 40) begin
        wr(5'd8, 16'd5);
        wr(5'd12, 16'd7);
      end
    end

    // R7 independent periods under one shared limit
    wr(5'd0, 16'd0);
    wr(5'd1, 16'd199);
    wr(5'd4, 16'd3); wr(5'd5, 16'd10); wr(5'd6, 16'd10);
    wr(5'd8, 16'd3); wr(5'd9, 16'd20); wr(5'd10, 16'd20);
    wr(5'd12, 16'd0); wr(5'd16, 16'd0);
    wr(5'd0, 16'd1);
    p0 = oc_pin[0]; p1 = oc_pin[1]; c0 = 0; c1 = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (oc_pin[0] != p0) c0++;
      if (oc_pin[1] != p1) c1++;
      p0 = oc_pin[0]; p1 = oc_pin[1];
    end
    check("R7 ch0 toggles per period", 16'(c0), 16'd20);
    check("R7 ch1 toggles per period", 16'(c1), 16'd10);

    // R9 arm relative to counter
    wr(5'd0, 16'd0);
    wr(5'd1, 16'd63);
    wr(5'd19, 16'd70);
    rd(5'd17, 16'd6, "R9 arm wraps");
    wr(5'd19, 16'd5);
    rd(5'd17, 16'd5, "R9 arm offset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule